// File: doc/BRIEF.md
# Ring Command Packet Decoder

This block walks a circular command queue held in memory, one 32-bit word at a time, and hands each recognised command header to the executors that sit beside it. Software places packets in the ring and rings a doorbell with the new write pointer, given as a byte offset. The decoder then reads from its own read pointer up to that write pointer. For each header it does one of four things. It steps over padding, it steps over packets of known length that nothing here acts on, it presents the header to the executors and waits for their done pulse, or it descends into a single level of indirect buffer.

The indirect buffer is a linear child queue. Its base and word count come from the packet that names it. When the child is drained, decoding returns to the ring at the word after the indirect packet. A header that is not recognised leaves the decoder in a sticky fault state that only reset clears. An indirect packet found inside an indirect buffer counts as unrecognised.

States: IDLE (nothing pending), CHECK (compare the read and write pointers of the active queue), FETCH (read a header), DISPATCH (present a header and wait for done), IB_BASE and IB_SIZE (read the two payload words of an indirect packet), FAULT (stopped). Transitions:
- IDLE goes to CHECK on a doorbell.
- CHECK goes to FETCH when the active queue holds words. It goes to IDLE when the ring is empty and no doorbell is arriving. It stays in CHECK, returning to the ring, when the child is empty.
- FETCH goes to CHECK, DISPATCH, IB_BASE or FAULT on the read response, according to the header class.
- DISPATCH goes to CHECK on done.
- IB_BASE goes to IB_SIZE, and IB_SIZE goes to CHECK, each on its read response.

Top module: `cmd_ring_decoder`

## Requirements
- R1: After reset, busy_o, err_o, ib_active_o, mem_req_o and cmd_valid_o are 0 and rptr_o is 0.
- R2: Opcodes 0x01, 0x02, 0x05, 0x06, 0x08, 0x0C and 0x0E are executor commands. The decoder raises cmd_valid_o with the full header on cmd_header_o, the opcode (header bits 7:0) on cmd_opcode_o and the sub-opcode (bits 15:8) on cmd_subop_o. It holds them stable until cmd_done_i. Commands are presented in queue order, and no other header is ever presented.
- R3: The read pointer moves past the 4-byte header as soon as the header is read. On cmd_done_i it moves on by 4 times cmd_words_i, the payload word count the executor consumed.
- R4: Opcode 0x00 is padding. The read pointer skips a further 4 times the 14-bit count in header bits 29:16, and the padding words are never read.
- R5: Opcodes 0x07, 0x0A and 0x0D are stepped over without dispatch, with 2, 4 and 3 payload words respectively.
- R6: The ring read pointer wraps modulo RING_BYTES, which is a power of two, and memory is read at ring_base_i plus the read pointer.
- R7: A doorbell that arrives while the decoder is busy only updates the write pointer. Decoding continues through to the new value without stopping.
- R8: When the ring read pointer equals the write pointer, busy_o falls and no memory or command activity remains.
- R9: Opcode 0x04 is an indirect packet. Its first payload word is the child's byte base address and its second is the child's size in words. The decoder runs the child from offset 0 up to size×4 with ib_active_o high, then resumes the ring after the packet. A size of 0 returns to the ring at once.
- R10: Any other opcode, and 0x04 inside a child, sets err_o. err_o stays set until reset, and busy_o is held low. The read pointer stops just past the offending header, and later doorbells start nothing.
- R11: Only one transaction is outstanding at a time. mem_req_o and cmd_valid_o are never high together, and mem_req_o holds its address until mem_rvalid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_i | input | ADDR_W | Byte address of the ring in memory |
| db_valid_i | input | 1 | Doorbell strobe |
| db_wptr_i | input | log2(RING_BYTES) | New ring write pointer, byte offset |
| mem_req_o | output | 1 | Read request, held until the response arrives |
| mem_addr_o | output | ADDR_W | Byte address of the word being read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response word |
| cmd_valid_o | output | 1 | A header is presented to the executors |
| cmd_opcode_o | output | 8 | Header bits 7:0 |
| cmd_subop_o | output | 8 | Header bits 15:8 |
| cmd_header_o | output | 32 | Full header word |
| cmd_done_i | input | 1 | Executor has finished the presented command |
| cmd_words_i | input | CW_W | Payload words the executor consumed |
| ib_active_o | output | 1 | Decoding from the indirect buffer |
| busy_o | output | 1 | Processing flag |
| err_o | output | 1 | Sticky fault flag |
| rptr_o | output | log2(RING_BYTES) | Ring read pointer, byte offset |

## Verification
A doorbell sampled at one edge makes busy_o high after that edge. The first read request appears one cycle later, because CHECK lies in between. Each header or indirect payload word costs the request cycle plus the response cycle, so a dispatch shows on cmd_valid_o in the cycle after the header response. The read pointer takes its new value at the edge that accepts a response or a done pulse. The bench interprets the same memory image with its own behavioural walker and keeps a queue of the headers it expects. Every falling edge it checks each new dispatch against the head of that queue and confirms that no read overlaps a dispatch. The pointer, busy and error values are compared only once the decoder has been quiet for several cycles, so no check depends on the exact cycle count of a packet.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_FETCH, ST_DISPATCH, ST_IB_BASE, ST_IB_SIZE, ST_FAULT
    } dec_state_t;

    typedef enum logic [2:0] {
        K_PAD, K_EXEC, K_JUMP, K_SKIP, K_BAD
    } op_kind_t;

    localparam logic [7:0] OP_PAD  = 8'h00;
    localparam logic [7:0] OP_JUMP = 8'h04;
endpackage

// File: rtl/cmdq_classify.sv
module cmdq_classify
    import cmdq_pkg::*;
#(
    parameter int ADV_W = 18
) (
    input  logic [7:0]       op_i,
    input  logic [13:0]      pad_cnt_i,
    input  logic             nested_i,
    output op_kind_t         kind_o,
    output logic [ADV_W-1:0] adv_o
);
    logic [ADV_W-1:0] extra;

    always_comb begin
        kind_o = K_BAD;
        extra  = '0;
        case (op_i)
            OP_PAD: begin
                kind_o = K_PAD;
                extra  = ADV_W'({pad_cnt_i, 2'b00});
            end
            8'h01, 8'h02, 8'h05, 8'h06, 8'h08, 8'h0C, 8'h0E: kind_o = K_EXEC;
            OP_JUMP: kind_o = nested_i ? K_BAD : K_JUMP;
            8'h07: begin kind_o = K_SKIP; extra = ADV_W'(8);  end
            8'h0A: begin kind_o = K_SKIP; extra = ADV_W'(16); end
            8'h0D: begin kind_o = K_SKIP; extra = ADV_W'(12); end
            default: kind_o = K_BAD;
        endcase
        // header word itself is always consumed
        adv_o = ADV_W'(4) + extra;
    end
endmodule

// File: rtl/cmdq_qptr.sv
module cmdq_qptr #(
    parameter int PW    = 8,
    parameter int ADV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wptr_i,
    input  logic [PW-1:0]    wptr_i,
    input  logic             clr_rptr_i,
    input  logic             adv_i,
    input  logic [ADV_W-1:0] adv_bytes_i,
    output logic [PW-1:0]    rptr_o,
    output logic             empty_o
);
    logic [PW-1:0] rptr_q;
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] step;

    // truncation to PW bits gives the modulo wrap
    assign step = PW'(adv_bytes_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q <= '0;
            wptr_q <= '0;
        end else begin
            if (load_wptr_i)
                wptr_q <= wptr_i;
            if (clr_rptr_i)
                rptr_q <= '0;
            else if (adv_i)
                rptr_q <= rptr_q + step;
        end
    end

    assign rptr_o  = rptr_q;
    assign empty_o = (rptr_q == wptr_q);
endmodule

// File: rtl/cmd_ring_decoder.sv
module cmd_ring_decoder
    import cmdq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int RING_BYTES = 256,
    parameter int IB_SIZE_W  = 12,
    parameter int CW_W       = 8,
    localparam int RP_W      = $clog2(RING_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base_i,
    input  logic              db_valid_i,
    input  logic [RP_W-1:0]   db_wptr_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              cmd_valid_o,
    output logic [7:0]        cmd_opcode_o,
    output logic [7:0]        cmd_subop_o,
    output logic [31:0]       cmd_header_o,
    input  logic              cmd_done_i,
    input  logic [CW_W-1:0]   cmd_words_i,
    output logic              ib_active_o,
    output logic              busy_o,
    output logic              err_o,
    output logic [RP_W-1:0]   rptr_o
);
    localparam int CP_W  = IB_SIZE_W + 2;
    localparam int ADV_W = (CW_W + 3 > 18) ? CW_W + 3 : 18;

    dec_state_t state, state_n;

    logic [31:0]       hdr_q;
    logic [ADDR_W-1:0] ib_base_q;
    logic              in_child;

    logic              adv_en;
    logic [ADV_W-1:0]  adv_amt;
    logic              hdr_ld, base_ld, ib_ld, leave_child;

    op_kind_t          kind;
    logic [ADV_W-1:0]  cls_adv;

    logic [RP_W-1:0]   r_rptr;
    logic              r_empty;
    logic [CP_W-1:0]   c_rptr;
    logic              c_empty;

    cmdq_classify #(.ADV_W(ADV_W)) u_classify (
        .op_i      (mem_rdata_i[7:0]),
        .pad_cnt_i (mem_rdata_i[29:16]),
        .nested_i  (in_child),
        .kind_o    (kind),
        .adv_o     (cls_adv)
    );

    // ring queue: write pointer from the doorbell, wraps at RING_BYTES
    cmdq_qptr #(.PW(RP_W), .ADV_W(ADV_W)) u_ring_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_wptr_i (db_valid_i),
        .wptr_i      (db_wptr_i),
        .clr_rptr_i  (1'b0),
        .adv_i       (adv_en && !in_child),
        .adv_bytes_i (adv_amt),
        .rptr_o      (r_rptr),
        .empty_o     (r_empty)
    );

    // child queue: loaded by an indirect packet
    cmdq_qptr #(.PW(CP_W), .ADV_W(ADV_W)) u_child_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_wptr_i (ib_ld),
        .wptr_i      ({mem_rdata_i[IB_SIZE_W-1:0], 2'b00}),
        .clr_rptr_i  (ib_ld),
        .adv_i       (adv_en && in_child),
        .adv_bytes_i (adv_amt),
        .rptr_o      (c_rptr),
        .empty_o     (c_empty)
    );

    // state register and per-packet storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hdr_q     <= '0;
            ib_base_q <= '0;
            in_child  <= 1'b0;
        end else begin
            state <= state_n;
            if (hdr_ld)
                hdr_q <= mem_rdata_i;
            if (base_ld)
                ib_base_q <= ADDR_W'(mem_rdata_i);
            if (ib_ld)
                in_child <= 1'b1;
            else if (leave_child)
                in_child <= 1'b0;
        end
    end

    // transitions and pointer control
    always_comb begin
        state_n     = state;
        adv_en      = 1'b0;
        adv_amt     = '0;
        hdr_ld      = 1'b0;
        base_ld     = 1'b0;
        ib_ld       = 1'b0;
        leave_child = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (db_valid_i)
                    state_n = ST_CHECK;
            end
            ST_CHECK: begin
                if (in_child) begin
                    if (c_empty)
                        leave_child = 1'b1;
                    else
                        state_n = ST_FETCH;
                end else if (!r_empty) begin
                    state_n = ST_FETCH;
                end else if (!db_valid_i) begin
                    // a doorbell this cycle keeps us checking
                    state_n = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (mem_rvalid_i) begin
                    hdr_ld  = 1'b1;
                    adv_en  = 1'b1;
                    adv_amt = (kind == K_PAD || kind == K_SKIP) ? cls_adv : ADV_W'(4);
                    unique case (kind)
                        K_EXEC:  state_n = ST_DISPATCH;
                        K_JUMP:  state_n = ST_IB_BASE;
                        K_BAD:   state_n = ST_FAULT;
                        default: state_n = ST_CHECK;
                    endcase
                end
            end
            ST_DISPATCH: begin
                if (cmd_done_i) begin
                    adv_en  = 1'b1;
                    adv_amt = ADV_W'({cmd_words_i, 2'b00});
                    state_n = ST_CHECK;
                end
            end
            ST_IB_BASE: begin
                if (mem_rvalid_i) begin
                    base_ld = 1'b1;
                    adv_en  = 1'b1;
                    adv_amt = ADV_W'(4);
                    state_n = ST_IB_SIZE;
                end
            end
            ST_IB_SIZE: begin
                if (mem_rvalid_i) begin
                    ib_ld   = 1'b1;
                    adv_en  = 1'b1;
                    adv_amt = ADV_W'(4);
                    state_n = ST_CHECK;
                end
            end
            ST_FAULT: state_n = ST_FAULT;
            default:  state_n = ST_FAULT;
        endcase
    end

    // port outputs
    always_comb begin
        mem_req_o    = (state == ST_FETCH) || (state == ST_IB_BASE) || (state == ST_IB_SIZE);
        mem_addr_o   = in_child ? (ib_base_q + ADDR_W'(c_rptr))
                                : (ring_base_i + ADDR_W'(r_rptr));
        cmd_valid_o  = (state == ST_DISPATCH);
        cmd_header_o = hdr_q;
        cmd_opcode_o = hdr_q[7:0];
        cmd_subop_o  = hdr_q[15:8];
        ib_active_o  = in_child;
        busy_o       = (state != ST_IDLE) && (state != ST_FAULT);
        err_o        = (state == ST_FAULT);
        rptr_o       = r_rptr;
    end

    // checks placed beside the control they guard
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

    assert_one_txn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_o, cmd_valid_o}));

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_header_o));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o && !busy_o);

    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o && !cmd_valid_o);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !cmd_valid_o);

    assert_dbell_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && db_valid_i |=> busy_o || err_o);

    assert_child_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ib_active_o) |-> $past(mem_rvalid_i));
endmodule

// File: tb/test_cmd_ring_decoder.sv
module test_cmd_ring_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int RB         = 256;
    localparam int ADDR_W     = 32;
    localparam int IB_SIZE_W  = 12;
    localparam int CW_W       = 8;
    localparam int RP_W       = $clog2(RB);
    localparam int CHILD_SPAN = 1 << (IB_SIZE_W + 2);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] ring_base;
    logic              db_valid;
    logic [RP_W-1:0]   db_wptr;
    logic              mem_req_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic              mem_rvalid;
    logic [31:0]       mem_rdata;
    logic              cmd_valid_o;
    logic [7:0]        cmd_opcode_o;
    logic [7:0]        cmd_subop_o;
    logic [31:0]       cmd_header_o;
    logic              cmd_done;
    logic [CW_W-1:0]   cmd_words;
    logic              ib_active_o;
    logic              busy_o;
    logic              err_o;
    logic [RP_W-1:0]   rptr_o;

    logic [31:0] mem [0:1023];
    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_ring_decoder #(.ADDR_W(ADDR_W), .RING_BYTES(RB), .IB_SIZE_W(IB_SIZE_W), .CW_W(CW_W))
    i_cmd_ring_decoder (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base),
        .db_valid_i(db_valid), .db_wptr_i(db_wptr),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .cmd_valid_o(cmd_valid_o), .cmd_opcode_o(cmd_opcode_o),
        .cmd_subop_o(cmd_subop_o), .cmd_header_o(cmd_header_o),
        .cmd_done_i(cmd_done), .cmd_words_i(cmd_words),
        .ib_active_o(ib_active_o), .busy_o(busy_o), .err_o(err_o), .rptr_o(rptr_o)
    );

    // memory: answers each request one cycle later
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req_o && !mem_rvalid;
            mem_rdata  <= mem[mem_addr_o[11:2]];
        end
    end

    // executor: done after three cycles, consuming the header's bits 23:16 words
    int ex_cnt;
    assign cmd_words = cmd_header_o[23:16];
    always @(posedge clk) begin
        if (!rst_n) begin
            cmd_done <= 1'b0;
            ex_cnt   <= 0;
        end else if (cmd_done) begin
            cmd_done <= 1'b0;
            ex_cnt   <= 0;
        end else if (cmd_valid_o) begin
            if (ex_cnt == 2) cmd_done <= 1'b1;
            else             ex_cnt   <= ex_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [32:0] exp_q[$];
    int  m_rptr, m_wptr, wp;
    bit  m_err;

    function automatic bit is_exec(input logic [7:0] op);
        return op == 8'h01 || op == 8'h02 || op == 8'h05 || op == 8'h06 ||
               op == 8'h08 || op == 8'h0C || op == 8'h0E;
    endfunction

    function automatic int skip_len(input logic [7:0] op);
        case (op)
            8'h07:   return 8;
            8'h0A:   return 16;
            8'h0D:   return 12;
            default: return 0;
        endcase
    endfunction

    task automatic run_simple(input logic [31:0] h, input bit child, inout int p, input int wrapm);
        logic [7:0] op;
        op = h[7:0];
        if (op == 8'h00) p = (p + 4 * int'(h[29:16])) % wrapm;
        else if (is_exec(op)) begin
            exp_q.push_back({child, h});
            p = (p + 4 * int'(h[23:16])) % wrapm;
        end else if (skip_len(op) > 0) p = (p + skip_len(op)) % wrapm;
        else m_err = 1;
    endtask

    task automatic model_walk();
        logic [31:0] h, hh;
        int b, s, c;
        while (!m_err && m_rptr != m_wptr) begin
            h = mem[(int'(ring_base) + m_rptr) >> 2];
            m_rptr = (m_rptr + 4) % RB;
            if (h[7:0] == 8'h04) begin
                b = int'(mem[(int'(ring_base) + m_rptr) >> 2]);
                m_rptr = (m_rptr + 4) % RB;
                s = int'(mem[(int'(ring_base) + m_rptr) >> 2] & ((1 << IB_SIZE_W) - 1));
                m_rptr = (m_rptr + 4) % RB;
                c = 0;
                while (!m_err && c != s * 4) begin
                    hh = mem[(b + c) >> 2];
                    c = c + 4;
                    if (hh[7:0] == 8'h04) m_err = 1;
                    else run_simple(hh, 1'b1, c, CHILD_SPAN);
                end
            end else begin
                run_simple(h, 1'b0, m_rptr, RB);
            end
        end
    endtask

    // ---------------- per-clock comparison ----------------
    bit prev_v;
    always @(negedge clk) begin
        logic [32:0] e;
        if (!rst_n) begin
            prev_v = 0;
        end else begin
            if (mem_req_o && cmd_valid_o)
                check(0, "R11", "read overlaps dispatch", 1, 0);
            if (cmd_valid_o && !prev_v) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected dispatch", {ib_active_o, cmd_header_o}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({ib_active_o, cmd_header_o} == e, "R2/R9", "dispatched {ib,header}",
                          {ib_active_o, cmd_header_o}, e);
                    check(cmd_opcode_o == e[7:0] && cmd_subop_o == e[15:8], "R2",
                          "opcode/subop fields", {cmd_subop_o, cmd_opcode_o}, e[15:0]);
                end
            end
            prev_v = cmd_valid_o;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic push(input logic [31:0] w);
        mem[(int'(ring_base) + wp) >> 2] = w;
        wp = (wp + 4) % RB;
    endtask

    task automatic push_exec(input logic [7:0] op, input logic [7:0] sub, input int n);
        push({8'h00, 8'(n), sub, op});
        for (int i = 0; i < n; i++) push(32'hC0DE_0000 + i);
    endtask

    task automatic doorbell();
        @(negedge clk);
        db_valid = 1'b1;
        db_wptr  = RP_W'(wp);
        @(negedge clk);
        db_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        for (int i = 0; i < 4000 && q < 4; i++) begin
            @(negedge clk);
            if (!busy_o) q++; else q = 0;
        end
    endtask

    task automatic ring_and_check(input string req);
        m_wptr = wp;
        model_walk();
        doorbell();
        wait_quiet();
        check(exp_q.size() == 0, req, "all expected commands dispatched", exp_q.size(), 0);
        check(rptr_o == RP_W'(m_rptr), req, "ring read pointer", rptr_o, m_rptr);
        check(busy_o == 1'b0, "R8", "busy after drain", busy_o, 0);
        check(err_o == m_err, req, "error flag", err_o, m_err);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        m_rptr = 0; m_wptr = 0; wp = 0; m_err = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog (R8): actual still running expected finished");
        finish_run();
    end

    initial begin
        int start, bytes;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hFFFF_FFFF;
        ring_base = '0;
        db_valid  = 1'b0;
        db_wptr   = '0;
        do_reset();

        // R1: reset state
        check(busy_o == 0 && err_o == 0 && ib_active_o == 0, "R1", "flags after reset",
              {busy_o, err_o, ib_active_o}, 0);
        check(mem_req_o == 0 && cmd_valid_o == 0, "R1", "no activity after reset",
              {mem_req_o, cmd_valid_o}, 0);
        check(rptr_o == 0, "R1", "read pointer after reset", rptr_o, 0);

        // R2 R3 R4: executor commands around padding (pads hold a bad opcode)
        push_exec(8'h01, 8'h00, 3);
        push({2'b00, 14'd2, 16'h0000});
        push(32'hFFFF_FFFF); push(32'hFFFF_FFFF);
        push_exec(8'h05, 8'h07, 1);
        ring_and_check("R4");

        // R5: fixed-length packets stepped over
        push(32'h0000_000A); for (int i = 0; i < 4; i++) push(32'hFFFF_FFFF);
        push(32'h0000_0007); for (int i = 0; i < 2; i++) push(32'hFFFF_FFFF);
        push(32'h0000_000D); for (int i = 0; i < 3; i++) push(32'hFFFF_FFFF);
        push_exec(8'h0C, 8'h02, 0);
        ring_and_check("R5");

        // R9: indirect buffer, then a zero-size one
        mem[32'h800 >> 2]       = {8'h00, 8'd1, 8'h01, 8'h02};
        mem[(32'h800 >> 2) + 1] = 32'h1234_5678;
        mem[(32'h800 >> 2) + 2] = {2'b00, 14'd1, 16'h0000};
        mem[(32'h800 >> 2) + 3] = 32'hFFFF_FFFF;
        mem[(32'h800 >> 2) + 4] = {8'h00, 8'd0, 8'h00, 8'h06};
        push_exec(8'h08, 8'h00, 1);
        push(32'h0000_0004); push(32'h0000_0800); push(32'd5);
        push_exec(8'h0E, 8'h03, 0);
        ring_and_check("R9");
        check(ib_active_o == 0, "R9", "returned to ring", ib_active_o, 0);
        push(32'h0000_0004); push(32'h0000_0900); push(32'd0);
        push_exec(8'h02, 8'h00, 2);
        ring_and_check("R9");

        // R7: doorbell while busy extends the work
        for (int i = 0; i < 3; i++) push_exec(8'h01, 8'h01, 2);
        m_wptr = wp;
        model_walk();
        doorbell();
        repeat (3) @(negedge clk);
        check(busy_o == 1, "R7", "busy before second doorbell", busy_o, 1);
        push_exec(8'h06, 8'h00, 0);
        push_exec(8'h06, 8'h01, 1);
        ring_and_check("R7");

        // R6: wrap of the ring read pointer
        start = m_rptr;
        bytes = 0;
        for (int i = 0; i < 8; i++) begin push_exec(8'h02, 8'h00, 5); bytes += 24; end
        ring_and_check("R6");
        for (int i = 0; i < 4; i++) begin push_exec(8'h02, 8'h01, 5); bytes += 24; end
        ring_and_check("R6");
        check(start + bytes >= RB, "R6", "ring end crossed", start + bytes, RB);
        check(rptr_o == RP_W'((start + bytes) % RB), "R6", "wrapped pointer",
              rptr_o, (start + bytes) % RB);

        // R10: unknown opcode is sticky
        start = m_rptr;
        push(32'h0000_003F);
        push_exec(8'h01, 8'h00, 0);
        ring_and_check("R10");
        check(err_o == 1 && rptr_o == RP_W'((start + 4) % RB), "R10", "stopped past bad header",
              rptr_o, (start + 4) % RB);
        push_exec(8'h05, 8'h00, 0);
        doorbell();
        repeat (10) @(negedge clk);
        check(err_o == 1 && busy_o == 0, "R10", "still faulted after doorbell",
              {err_o, busy_o}, 2);
        check(rptr_o == RP_W'((start + 4) % RB), "R10", "pointer frozen", rptr_o, (start + 4) % RB);

        do_reset();
        check(err_o == 0 && rptr_o == 0, "R1", "reset clears fault", {err_o, rptr_o}, 0);

        // R10: indirect packet inside a child
        mem[32'hA00 >> 2] = 32'h0000_0004;
        push(32'h0000_0004); push(32'h0000_0A00); push(32'd1);
        ring_and_check("R10");
        check(err_o == 1 && rptr_o == 12, "R10", "nested indirect faults", {err_o, rptr_o}, 12'h10C);

        finish_run();
    end
endmodule